// File: doc/BRIEF.md
# Execute-Stage Operand Bypass and Load Interlock

This block sits beside the execute stage of a five-stage in-order pipeline with a 32-entry register file. For each of the two ALU operands it decides whether the value read from the register file is stale. If it is, it substitutes the result held in the EX/MEM or MEM/WB pipeline register. The whole decision is combinational, so the chosen operands are valid in the same cycle as the inputs that produce them.

It also serves a store that has reached the memory stage. If the instruction one stage ahead of that store was a load that wrote the store's data register, the loaded value replaces the stale store data. A load directly followed by a store that needs the loaded value only as data therefore does not stall. A stall request goes up only when a load in ID/EX feeds a register that the instruction in IF/ID needs in the execute stage: any source of a non-store, or the base register of a store.

Top module: `fwd_unit`

## Requirements
- R1: Register addresses are 5 bits wide and every data value is 32 bits wide. Address 31 and full 32-bit values forward without truncation.
- R2: An ALU operand takes a bypass value only when that stage's write flag is high and its destination address equals the operand's source address. EX/MEM supplies `memResult` and MEM/WB supplies `wbResult`.
- R3: When both EX/MEM and MEM/WB qualify for the same operand, the operand takes `memResult`.
- R4: When neither stage qualifies, the operand equals its register-file read value.
- R5: A destination address of 0 never matches. An operand whose source address is 0 always equals its register-file read value.
- R6: All outputs are a combinational function of the present inputs and follow an input change within the same clock cycle, with no clocked state.
- R7: `storeDataOut` equals `wbResult` when `wbRegWrite` and `wbIsLoad` are both high, `wbRd` is nonzero, and `wbRd` equals `memStoreSrc`.
- R8: In every other case, `storeDataOut` equals `memStoreData`.
- R9: `stallReq` is high when `exIsLoad` and `exRegWrite` are high, `exRd` is nonzero, and a non-store in IF/ID uses either source that equals `exRd`.
- R10: For a store in IF/ID, `stallReq` is high when its base source (source A, with `idUsesA` high) equals a nonzero `exRd` of a writing load.
- R11: For a store in IF/ID whose only dependency on the load is its data source (source B), `stallReq` stays low.
- R12: `stallReq` is low whenever `exIsLoad` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| exSrcAddrA | input | 5 | Source address of ALU operand A in ID/EX |
| exSrcAddrB | input | 5 | Source address of ALU operand B in ID/EX |
| exReadDataA | input | 32 | Register-file value read for operand A |
| exReadDataB | input | 32 | Register-file value read for operand B |
| exRd | input | 5 | Destination address of the instruction in ID/EX |
| exRegWrite | input | 1 | Instruction in ID/EX writes the register file |
| exIsLoad | input | 1 | Instruction in ID/EX is a load |
| idSrcAddrA | input | 5 | Source A (base for a store) of the instruction in IF/ID |
| idSrcAddrB | input | 5 | Source B (store data for a store) of the instruction in IF/ID |
| idUsesA | input | 1 | IF/ID instruction reads source A |
| idUsesB | input | 1 | IF/ID instruction reads source B |
| idIsStore | input | 1 | IF/ID instruction is a store |
| memRd | input | 5 | Destination address in EX/MEM |
| memRegWrite | input | 1 | EX/MEM instruction writes the register file |
| memResult | input | 32 | Result carried in EX/MEM |
| memStoreSrc | input | 5 | Data-source address of the store in EX/MEM |
| memStoreData | input | 32 | Store data carried in EX/MEM |
| wbRd | input | 5 | Destination address in MEM/WB |
| wbRegWrite | input | 1 | MEM/WB instruction writes the register file |
| wbIsLoad | input | 1 | MEM/WB instruction is a load |
| wbResult | input | 32 | Write-back value in MEM/WB |
| aluOpA | output | 32 | Selected ALU operand A |
| aluOpB | output | 32 | Selected ALU operand B |
| storeDataOut | output | 32 | Data to write for the store in the memory stage |
| stallReq | output | 1 | Request to hold IF/ID for one cycle |

## Verification
Every result is due in the same cycle as the stimulus that causes it, because no register lies between any input and any output. The bench applies each vector one time unit after a rising edge and compares all four outputs with its behavioural model at the following falling edge, inside the same cycle. One dedicated check changes an input in the middle of the low phase and expects the new operand before the next edge.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  localparam int NUM_OPS = 2;
  localparam int SEL_W   = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_RF    = 2'd0,
    SEL_EXMEM = 2'd1,
    SEL_MEMWB = 2'd2
  } opSel_e;

  typedef struct packed {
    logic [NUM_OPS-1:0][SEL_W-1:0] opSel;
    logic                          storeFromWb;
    logic                          stall;
  } fwdCtrl_t;

endpackage

// File: rtl/fwd_ctrl.sv
module fwd_ctrl
  import fwd_pkg::*;
#(
  parameter int ADDR_W        = 5,
  parameter int STORE_DATA_OP = 1
) (
  input  logic [NUM_OPS-1:0][ADDR_W-1:0] srcAddr,
  input  logic [ADDR_W-1:0]              memRd,
  input  logic                           memRegWrite,
  input  logic [ADDR_W-1:0]              wbRd,
  input  logic                           wbRegWrite,
  input  logic                           wbIsLoad,
  input  logic [ADDR_W-1:0]              memStoreSrc,
  input  logic [ADDR_W-1:0]              exRd,
  input  logic                           exRegWrite,
  input  logic                           exIsLoad,
  input  logic [NUM_OPS-1:0][ADDR_W-1:0] idSrcAddr,
  input  logic [NUM_OPS-1:0]             idUses,
  input  logic                           idIsStore,
  output fwdCtrl_t                       ctrl
);

  logic [NUM_OPS-1:0][SEL_W-1:0] selVec;
  logic [NUM_OPS-1:0]            useHit;
  logic [NUM_OPS-1:0]            exempt;
  logic                          memLive;
  logic                          wbLive;
  logic                          loadLive;

  assign memLive  = memRegWrite && (memRd != '0);
  assign wbLive   = wbRegWrite && (wbRd != '0);
  assign loadLive = exIsLoad && exRegWrite && (exRd != '0);

  for (genvar g = 0; g < NUM_OPS; g++) begin : gOp
    logic memHit;
    logic wbHit;
    assign memHit    = memLive && (memRd == srcAddr[g]);
    assign wbHit     = wbLive && (wbRd == srcAddr[g]);
    assign selVec[g] = memHit ? SEL_EXMEM : (wbHit ? SEL_MEMWB : SEL_RF);
    assign useHit[g] = idUses[g] && (idSrcAddr[g] == exRd);
    if (g == STORE_DATA_OP) begin : gDataSlot
      assign exempt[g] = idIsStore;
    end else begin : gExecSlot
      assign exempt[g] = 1'b0;
    end
  end

  assign ctrl.opSel       = selVec;
  assign ctrl.storeFromWb = wbLive && wbIsLoad && (wbRd == memStoreSrc);
  assign ctrl.stall       = loadLive && |(useHit & ~exempt);

endmodule

// File: rtl/fwd_datapath.sv
module fwd_datapath
  import fwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  fwdCtrl_t                       ctrl,
  input  logic [NUM_OPS-1:0][DATA_W-1:0] rfData,
  input  logic [DATA_W-1:0]              memResult,
  input  logic [DATA_W-1:0]              wbResult,
  input  logic [DATA_W-1:0]              memStoreData,
  output logic [NUM_OPS-1:0][DATA_W-1:0] opOut,
  output logic [DATA_W-1:0]              storeDataOut
);

  for (genvar g = 0; g < NUM_OPS; g++) begin : gMux
    logic [DATA_W-1:0] pick;
    always_comb begin
      case (ctrl.opSel[g])
        SEL_EXMEM: pick = memResult;
        SEL_MEMWB: pick = wbResult;
        default:   pick = rfData[g];
      endcase
    end
    assign opOut[g] = pick;
  end

  assign storeDataOut = ctrl.storeFromWb ? wbResult : memStoreData;

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0] exSrcAddrA,
  input  logic [ADDR_W-1:0] exSrcAddrB,
  input  logic [DATA_W-1:0] exReadDataA,
  input  logic [DATA_W-1:0] exReadDataB,
  input  logic [ADDR_W-1:0] exRd,
  input  logic              exRegWrite,
  input  logic              exIsLoad,
  input  logic [ADDR_W-1:0] idSrcAddrA,
  input  logic [ADDR_W-1:0] idSrcAddrB,
  input  logic              idUsesA,
  input  logic              idUsesB,
  input  logic              idIsStore,
  input  logic [ADDR_W-1:0] memRd,
  input  logic              memRegWrite,
  input  logic [DATA_W-1:0] memResult,
  input  logic [ADDR_W-1:0] memStoreSrc,
  input  logic [DATA_W-1:0] memStoreData,
  input  logic [ADDR_W-1:0] wbRd,
  input  logic              wbRegWrite,
  input  logic              wbIsLoad,
  input  logic [DATA_W-1:0] wbResult,
  output logic [DATA_W-1:0] aluOpA,
  output logic [DATA_W-1:0] aluOpB,
  output logic [DATA_W-1:0] storeDataOut,
  output logic              stallReq
);

  fwdCtrl_t                       ctrl;
  logic [NUM_OPS-1:0][ADDR_W-1:0] srcVec;
  logic [NUM_OPS-1:0][ADDR_W-1:0] idSrcVec;
  logic [NUM_OPS-1:0]             idUseVec;
  logic [NUM_OPS-1:0][DATA_W-1:0] rfVec;
  logic [NUM_OPS-1:0][DATA_W-1:0] opVec;

  assign srcVec   = {exSrcAddrB, exSrcAddrA};
  assign idSrcVec = {idSrcAddrB, idSrcAddrA};
  assign idUseVec = {idUsesB, idUsesA};
  assign rfVec    = {exReadDataB, exReadDataA};

  fwd_ctrl #(.ADDR_W(ADDR_W), .STORE_DATA_OP(1)) uCtrl (
    .srcAddr    (srcVec),
    .memRd      (memRd),
    .memRegWrite(memRegWrite),
    .wbRd       (wbRd),
    .wbRegWrite (wbRegWrite),
    .wbIsLoad   (wbIsLoad),
    .memStoreSrc(memStoreSrc),
    .exRd       (exRd),
    .exRegWrite (exRegWrite),
    .exIsLoad   (exIsLoad),
    .idSrcAddr  (idSrcVec),
    .idUses     (idUseVec),
    .idIsStore  (idIsStore),
    .ctrl       (ctrl)
  );

  fwd_datapath #(.DATA_W(DATA_W)) uData (
    .ctrl        (ctrl),
    .rfData      (rfVec),
    .memResult   (memResult),
    .wbResult    (wbResult),
    .memStoreData(memStoreData),
    .opOut       (opVec),
    .storeDataOut(storeDataOut)
  );

  assign aluOpA   = opVec[0];
  assign aluOpB   = opVec[1];
  assign stallReq = ctrl.stall;

  always_comb begin
    if (memRegWrite && memRd != '0 && memRd == exSrcAddrA)
      AST_EXMEM_WINS_A: assert (aluOpA == memResult) else $error("EX/MEM bypass lost on A"); // R3
    if (memRegWrite && memRd != '0 && memRd == exSrcAddrB)
      AST_EXMEM_WINS_B: assert (aluOpB == memResult) else $error("EX/MEM bypass lost on B"); // R3
    if (exSrcAddrA == '0)
      AST_ZERO_SRC_A: assert (aluOpA == exReadDataA) else $error("register 0 bypassed on A"); // R5
    if (exSrcAddrB == '0)
      AST_ZERO_SRC_B: assert (aluOpB == exReadDataB) else $error("register 0 bypassed on B"); // R5
    if (wbRegWrite && wbIsLoad && wbRd != '0 && wbRd == memStoreSrc)
      AST_STORE_FROM_LOAD: assert (storeDataOut == wbResult) else $error("store data not bypassed"); // R7
    if (!exIsLoad)
      AST_STALL_ONLY_LOAD: assert (!stallReq) else $error("stall without a load"); // R12
    if (idIsStore && !(idUsesA && idSrcAddrA == exRd))
      AST_STORE_DATA_NO_STALL: assert (!stallReq) else $error("store data dependency stalled"); // R11
  end

endmodule

// File: tb/tb_fwd_unit.sv
module tb_fwd_unit;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [4:0]  exSrcAddrA, exSrcAddrB, exRd, idSrcAddrA, idSrcAddrB;
  logic [4:0]  memRd, memStoreSrc, wbRd;
  logic [31:0] exReadDataA, exReadDataB, memResult, memStoreData, wbResult;
  logic        exRegWrite, exIsLoad, idUsesA, idUsesB, idIsStore;
  logic        memRegWrite, wbRegWrite, wbIsLoad;
  logic [31:0] aluOpA, aluOpB, storeDataOut;
  logic        stallReq;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;

  fwd_unit dut (.*);

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] refOp(input logic [4:0] src, input logic [31:0] rf);
    if (src == 0) return rf;
    if (memRegWrite && memRd == src) return memResult;
    if (wbRegWrite && wbRd == src) return wbResult;
    return rf;
  endfunction

  function automatic string opTag(input logic [4:0] src);
    bit m, w;
    m = memRegWrite && memRd == src && src != 0;
    w = wbRegWrite && wbRd == src && src != 0;
    if (src == 0) return "R5";
    if (m && w) return "R3";
    if (m || w) return "R2";
    return "R4";
  endfunction

  function automatic bit refFwdStore();
    return wbRegWrite && wbIsLoad && wbRd != 0 && wbRd == memStoreSrc;
  endfunction

  function automatic bit refStall(output string tag);
    bit baseDep, dataDep;
    baseDep = idUsesA && idSrcAddrA == exRd;
    dataDep = idUsesB && idSrcAddrB == exRd;
    if (!exIsLoad) begin tag = "R12"; return 1'b0; end
    if (idIsStore && baseDep) tag = "R10";
    else if (idIsStore) tag = "R11";
    else tag = "R9";
    if (!exRegWrite || exRd == 0) return 1'b0;
    if (idIsStore) return baseDep;
    return baseDep || dataDep;
  endfunction

  task automatic compareAll();
    string st;
    bit expStall;
    expStall = refStall(st);
    check(opTag(exSrcAddrA), "aluOpA", aluOpA, refOp(exSrcAddrA, exReadDataA));
    check(opTag(exSrcAddrB), "aluOpB", aluOpB, refOp(exSrcAddrB, exReadDataB));
    check(refFwdStore() ? "R7" : "R8", "storeDataOut", storeDataOut,
          refFwdStore() ? wbResult : memStoreData);
    check(st, "stallReq", {31'd0, stallReq}, {31'd0, expStall});
  endtask

  task automatic idle();
    {exSrcAddrA, exSrcAddrB, exRd, idSrcAddrA, idSrcAddrB, memRd, memStoreSrc, wbRd} = '0;
    {exReadDataA, exReadDataB, memResult, memStoreData, wbResult} = '0;
    {exRegWrite, exIsLoad, idUsesA, idUsesB, idIsStore, memRegWrite, wbRegWrite, wbIsLoad} = '0;
  endtask

  task automatic step();
    @(negedge clk);
    compareAll();
    @(posedge clk);
    #1;
  endtask

  initial begin
    idle();
    @(posedge clk); #1;
    // reset-like all-zero state: operands come from the (zero) register file, R4
    @(negedge clk);
    check("R4", "idle aluOpA", aluOpA, 32'h0);
    check("R12", "idle stallReq", {31'd0, stallReq}, 32'h0);
    @(posedge clk); #1;

    // every write-flag / match combination for both operands, R2 R3 R4
    for (int ca = 0; ca < 16; ca++) begin
      for (int cb = 0; cb < 16; cb++) begin
        idle();
        exSrcAddrA = 5'd7; exSrcAddrB = (ca == cb) ? 5'd7 : 5'd9;
        exReadDataA = 32'hA000_0000 + ca; exReadDataB = 32'hB000_0000 + cb;
        memResult = 32'h1111_0000 + cb; wbResult = 32'h2222_0000 + ca;
        memRegWrite = ca[0];
        wbRegWrite  = ca[1];
        memRd = ca[2] ? 5'd7 : (cb[2] ? 5'd9 : 5'd3);
        wbRd  = ca[3] ? 5'd7 : (cb[3] ? 5'd9 : 5'd4);
        step();
      end
    end

    // R1: top address and full-width data
    idle();
    exSrcAddrA = 5'd31; exReadDataA = 32'h0; memRegWrite = 1'b1; memRd = 5'd31; memResult = 32'hFFFF_FFFF;
    @(negedge clk);
    check("R1", "aluOpA width", aluOpA, 32'hFFFF_FFFF);
    @(posedge clk); #1;

    // R5: destination 0 in both stages
    idle();
    exReadDataA = 32'h1234_5678; memRegWrite = 1'b1; wbRegWrite = 1'b1;
    memResult = 32'hDEAD_0001; wbResult = 32'hDEAD_0002;
    @(negedge clk);
    check("R5", "aluOpA reg0", aluOpA, 32'h1234_5678);
    // R6: change mid-phase, result follows before next edge
    #0.5 memRd = 5'd0; exSrcAddrB = 5'd6; wbRd = 5'd6; #0.5;
    check("R6", "aluOpB same cycle", aluOpB, 32'hDEAD_0002);
    @(posedge clk); #1;

    // R7 / R8 store data
    idle();
    memStoreSrc = 5'd12; memStoreData = 32'h5555_AAAA; wbResult = 32'h0BAD_F00D;
    wbRegWrite = 1'b1; wbIsLoad = 1'b1; wbRd = 5'd12;
    @(negedge clk); check("R7", "store bypass", storeDataOut, 32'h0BAD_F00D); @(posedge clk); #1;
    wbIsLoad = 1'b0;
    @(negedge clk); check("R8", "non-load wb", storeDataOut, 32'h5555_AAAA); @(posedge clk); #1;
    wbIsLoad = 1'b1; wbRegWrite = 1'b0;
    @(negedge clk); check("R8", "wb no write", storeDataOut, 32'h5555_AAAA); @(posedge clk); #1;
    wbRegWrite = 1'b1; wbRd = 5'd0; memStoreSrc = 5'd0;
    @(negedge clk); check("R8", "wb dest 0", storeDataOut, 32'h5555_AAAA); @(posedge clk); #1;

    // stall cases
    idle();
    exIsLoad = 1'b1; exRegWrite = 1'b1; exRd = 5'd2;
    idUsesA = 1'b1; idUsesB = 1'b1; idSrcAddrA = 5'd8; idSrcAddrB = 5'd2;
    @(negedge clk); check("R9", "alu use B", {31'd0, stallReq}, 32'd1); @(posedge clk); #1;
    idSrcAddrA = 5'd2; idSrcAddrB = 5'd8;
    @(negedge clk); check("R9", "alu use A", {31'd0, stallReq}, 32'd1); @(posedge clk); #1;
    idIsStore = 1'b1;
    @(negedge clk); check("R10", "store base", {31'd0, stallReq}, 32'd1); @(posedge clk); #1;
    idSrcAddrA = 5'd8; idSrcAddrB = 5'd2;
    @(negedge clk); check("R11", "store data", {31'd0, stallReq}, 32'd0); @(posedge clk); #1;
    idIsStore = 1'b0; exIsLoad = 1'b0; idSrcAddrA = 5'd2;
    @(negedge clk); check("R12", "non-load", {31'd0, stallReq}, 32'd0); @(posedge clk); #1;
    exIsLoad = 1'b1; exRd = 5'd0; idSrcAddrA = 5'd0;
    @(negedge clk); check("R9", "load to reg0", {31'd0, stallReq}, 32'd0); @(posedge clk); #1;

    // random traffic over a narrow address range
    for (int i = 0; i < 3000; i++) begin
      exSrcAddrA = 5'($urandom_range(0, 3)); exSrcAddrB = 5'($urandom_range(0, 3));
      exRd = 5'($urandom_range(0, 3)); idSrcAddrA = 5'($urandom_range(0, 3));
      idSrcAddrB = 5'($urandom_range(0, 3)); memRd = 5'($urandom_range(0, 3));
      memStoreSrc = 5'($urandom_range(0, 3)); wbRd = 5'($urandom_range(0, 3));
      exReadDataA = $urandom; exReadDataB = $urandom; memResult = $urandom;
      memStoreData = $urandom; wbResult = $urandom;
      {exRegWrite, exIsLoad, idUsesA, idUsesB, idIsStore, memRegWrite, wbRegWrite, wbIsLoad} = 8'($urandom);
      step();
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

endmodule